// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block is the system-control register file and exception sequencer for a simple 32-bit in-order core. It holds six control registers: a processor mode word, an exception reason word, a resume address, a faulting-address capture, a free-running cycle counter and its match value. The pipeline raises synchronous exception requests with a 5-bit reason code. Six hardware interrupt lines and two software-set bits feed a masked, enabled interrupt decision. In the same cycle as a request, the unit answers with a fetch redirect and a target address.

Software reaches the registers through a numbered read/write port, as move-to and move-from instructions would. A return operation clears the exception-level flag and sends fetch back to the saved resume address. While the exception-level flag is set, interrupts are held off, and a further exception leaves the saved resume address untouched. The counter raises a timer interrupt on hardware level 5 when it reaches the match value.

Top module: `sctl_exc_unit`

## Requirements
- R1: Registers are selected by number: 8 fault address (read-only), 9 counter, 11 match value, 12 mode, 13 reason, 14 resume address; any other number reads 0.
- R2: Mode register layout: bits 15:8 interrupt mask (bit 8+k enables pending level k), bit 4 user flag, bit 1 exception level, bit 0 interrupt enable. Only these bits are stored, all others read 0, and reset value is 0.
- R3: An exception request asserts redirect in the same cycle with target 0x80000180; after the clock edge the exception-level bit is 1 and reason bits 6:2 hold the request's code.
- R4: The resume address takes the faulting instruction address; for a request flagged as in a branch delay slot it takes that address minus 4 and reason bit 31 is set, otherwise bit 31 is cleared.
- R5: A request taken while exception level is 1 still redirects and records its code but leaves the resume address and reason bit 31 unchanged.
- R6: Hardware line k sets reason bit 10+k one cycle after it is asserted, whatever its mask bit, and the bit follows the line.
- R7: An interrupt is taken only when (pending AND mask) is nonzero, interrupt enable is 1 and exception level is 0; it redirects to 0x80000180, saves the supplied next-instruction address as the resume address, writes code 0 and sets exception level.
- R8: An exception request in the same cycle as an acceptable interrupt wins, and a register write presented in that cycle is discarded.
- R9: The return operation asserts redirect with the resume address as target, and after the edge exception level is 0.
- R10: The counter increments by one every cycle and can be loaded by a write to register 9.
- R11: When the counter equals the match value, reason bit 15 becomes 1 on the following edge and stays 1 until the match register is written, which clears it.
- R12: Codes 4 and 5 (address errors) load the supplied faulting data address into register 8; other codes leave it unchanged.
- R13: Reason bits 9:8 (software interrupt levels) are writable; writes to the other reason bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request from the pipeline |
| exc_code | input | 5 | Reason code of the request |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_bad_addr | input | 32 | Faulting data address for address errors |
| next_pc | input | 32 | Address of the next instruction, saved on an interrupt |
| hw_irq | input | 6 | Hardware interrupt lines, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register number |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| eret | input | 1 | Return-from-exception request |
| redirect | output | 1 | Fetch must be redirected this cycle |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
The hardest case to reach is the exact interplay of pending, mask, enable and exception level. An interrupt must be taken on exactly the right cycle and no other. The bench sweeps every 8-bit mask against each hardware line, then sets exception level or clears enable through the mode register and raises lines into that state. Nested exceptions are reached by issuing a second request before any return. The timer match is reached by loading a match value a few counts ahead and tracking the edge on which the pending bit appears.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned XW = 32;
  localparam logic [XW-1:0] TRAP_VECTOR = 32'h8000_0180;

  localparam logic [4:0] SEL_FAULT  = 5'd8;
  localparam logic [4:0] SEL_TICK   = 5'd9;
  localparam logic [4:0] SEL_MATCH  = 5'd11;
  localparam logic [4:0] SEL_MODE   = 5'd12;
  localparam logic [4:0] SEL_REASON = 5'd13;
  localparam logic [4:0] SEL_RESUME = 5'd14;

  // mask 15:8, user 4, exception level 1, enable 0
  localparam logic [XW-1:0] MODE_KEEP = 32'h0000_FF13;
  localparam int unsigned MODE_EXL = 1;
  localparam int unsigned MODE_IE  = 0;

  function automatic logic is_addr_fault(input logic [4:0] code);
    return (code == 5'd4) || (code == 5'd5);
  endfunction

  function automatic logic [XW-1:0] resume_of(input logic [XW-1:0] pc, input logic slot);
    return slot ? (pc - 32'd4) : pc;
  endfunction
endpackage

// File: rtl/sctl_timer.sv
module sctl_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_wr,
  input  logic         match_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tick_q,
  output logic [W-1:0] match_q,
  output logic         fire
);
  logic hit;
  assign hit = (tick_q == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q  <= '0;
      match_q <= '1;
      fire    <= 1'b0;
    end else begin
      tick_q <= tick_wr ? wdata : tick_q + 1'b1;
      if (match_wr) match_q <= wdata;
      if (match_wr)      fire <= 1'b0;
      else if (hit)      fire <= 1'b1;
    end
  end

  p_tick_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_wr |=> tick_q == $past(tick_q) + 1'b1);
  p_fire_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_wr |=> !fire);
endmodule

// File: rtl/sctl_irq_gate.sv
module sctl_irq_gate #(
  parameter int unsigned HW = 6,
  localparam int unsigned PW = HW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hw_irq,
  input  logic          timer_fire,
  input  logic [1:0]    sw_pend,
  input  logic [PW-1:0] mask,
  input  logic          ie,
  input  logic          exl,
  output logic [PW-1:0] pend,
  output logic          take
);
  logic [HW-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= hw_irq;
  end

  assign pend[1:0] = sw_pend;
  for (genvar k = 0; k < HW; k++) begin : g_lvl
    if (k == HW - 1) begin : g_top
      assign pend[2+k] = line_q[k] | timer_fire;
    end else begin : g_plain
      assign pend[2+k] = line_q[k];
    end
  end

  assign take = ie && !exl && (|(pend & mask));

  p_line_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_irq[0] |=> pend[2]);
endmodule

// File: rtl/sctl_exc_unit.sv
module sctl_exc_unit #(
  parameter int unsigned HW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [31:0] exc_pc,
  input  logic        exc_in_slot,
  input  logic [31:0] exc_bad_addr,
  input  logic [31:0] next_pc,
  input  logic [5:0]  hw_irq,
  input  logic        reg_wr,
  input  logic [4:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eret,
  output logic        redirect,
  output logic [31:0] redirect_pc
);
  import sctl_pkg::*;
  localparam int unsigned PW = HW + 2;

  logic [31:0]   mode_q, resume_q, fault_q, tick_q, match_q;
  logic          slot_q;
  logic [4:0]    code_q;
  logic [1:0]    swp_q;
  logic [PW-1:0] pend;
  logic          timer_fire, irq_ok;

  // named events
  logic take_exc, take_irq, take_ret, wr_ok, exl;
  assign exl      = mode_q[MODE_EXL];
  assign take_exc = exc_req;
  assign take_ret = eret && !exc_req;
  assign take_irq = irq_ok && !exc_req && !eret;
  assign wr_ok    = reg_wr && !take_exc && !take_irq;

  assign redirect    = take_exc || take_ret || take_irq;
  assign redirect_pc = take_ret ? resume_q : TRAP_VECTOR;

  sctl_timer #(.W(32)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .tick_wr(wr_ok && reg_sel == SEL_TICK),
    .match_wr(wr_ok && reg_sel == SEL_MATCH),
    .wdata(reg_wdata),
    .tick_q(tick_q), .match_q(match_q), .fire(timer_fire)
  );

  sctl_irq_gate #(.HW(HW)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .hw_irq(hw_irq[HW-1:0]), .timer_fire(timer_fire), .sw_pend(swp_q),
    .mask(mode_q[8 +: PW]), .ie(mode_q[MODE_IE]), .exl(exl),
    .pend(pend), .take(irq_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      resume_q <= '0;
      fault_q  <= '0;
      slot_q   <= 1'b0;
      code_q   <= '0;
      swp_q    <= '0;
    end else if (take_exc) begin
      mode_q[MODE_EXL] <= 1'b1;
      code_q <= exc_code;
      if (!exl) begin
        resume_q <= resume_of(exc_pc, exc_in_slot);
        slot_q   <= exc_in_slot;
      end
      if (is_addr_fault(exc_code)) fault_q <= exc_bad_addr;
    end else if (take_irq) begin
      mode_q[MODE_EXL] <= 1'b1;
      code_q   <= 5'd0;
      resume_q <= next_pc;
      slot_q   <= 1'b0;
    end else begin
      if (take_ret) mode_q[MODE_EXL] <= 1'b0;
      if (wr_ok) begin
        case (reg_sel)
          SEL_MODE:   mode_q   <= reg_wdata & MODE_KEEP;
          SEL_REASON: swp_q    <= reg_wdata[9:8];
          SEL_RESUME: resume_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_FAULT:  reg_rdata = fault_q;
      SEL_TICK:   reg_rdata = tick_q;
      SEL_MATCH:  reg_rdata = match_q;
      SEL_MODE:   reg_rdata = mode_q;
      SEL_REASON: reg_rdata = {slot_q, 15'd0, pend, 1'b0, code_q, 2'b00};
      SEL_RESUME: reg_rdata = resume_q;
      default:    reg_rdata = '0;
    endcase
  end

  p_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> redirect && redirect_pc == TRAP_VECTOR);
  p_exl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> mode_q[MODE_EXL]);
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && mode_q[MODE_EXL] |=> $stable(resume_q) && $stable(slot_q));
  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[MODE_EXL] && !exc_req && !eret |-> !redirect);
  p_ret_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eret && !exc_req && !reg_wr |=> !mode_q[MODE_EXL]);
  p_fault_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !is_addr_fault(exc_code) |=> $stable(fault_q));
endmodule

// File: tb/test_sctl_exc_unit.sv
`timescale 1ns/1ps
module test_sctl_exc_unit;
  localparam logic [31:0] VEC = 32'h8000_0180;
  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_req = 0, exc_in_slot = 0, reg_wr = 0, eret = 0;
  logic [4:0] exc_code = 0, reg_sel = 0;
  logic [31:0] exc_pc = 0, exc_bad_addr = 0, next_pc = 0, reg_wdata = 0;
  logic [5:0] hw_irq = 0;
  logic [31:0] reg_rdata, redirect_pc;
  logic redirect;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sctl_exc_unit i_sctl_exc_unit (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_in_slot(exc_in_slot), .exc_bad_addr(exc_bad_addr),
    .next_pc(next_pc), .hw_irq(hw_irq), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eret(eret),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] v);
    reg_sel = sel; #0.1; v = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] v);
    reg_wr = 1; reg_sel = sel; reg_wdata = v; tick(); reg_wr = 0;
  endtask

  task automatic do_ret(input logic [31:0] exp_pc);
    eret = 1; #0.2;
    chk("R9 redirect", {31'd0, redirect}, 32'd1);
    chk("R9 target", redirect_pc, exp_pc);
    tick(); eret = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] v, c, exp_resume, exp_fault;
    logic [4:0] codes [12];
    codes = '{5'd0, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd15};
    repeat (3) tick();
    rst_n = 1; tick();

    // reset state and numbering
    rd(12, v); chk("R2 reset mode", v, 32'd0);
    rd(13, v); chk("R1 reset reason", v, 32'd0);
    rd(8, v);  chk("R1 reset fault", v, 32'd0);
    rd(11, v); chk("R1 reset match", v, 32'hFFFF_FFFF);
    chk("R3 no redirect at reset", {31'd0, redirect}, 32'd0);
    for (int s = 0; s < 32; s++) begin
      if (!(s inside {8, 9, 11, 12, 13, 14})) begin
        rd(s[4:0], v); chk("R1 unmapped reads 0", v, 32'd0);
      end
    end
    wr(14, 32'h1234_5678); rd(14, v); chk("R1 resume write", v, 32'h1234_5678);
    wr(8, 32'hFFFF_FFFF); rd(8, v); chk("R1 fault read-only", v, 32'd0);

    // mode layout
    for (int k = 0; k < 16; k++) begin
      logic [31:0] p;
      p = (32'h9E37_79B9 * (k + 1)) ^ {k[7:0], k[7:0], k[7:0], k[7:0]};
      wr(12, p); rd(12, v); chk("R2 mode stored bits", v, p & 32'h0000_FF13);
    end
    wr(12, 0);

    // counter
    wr(9, 32'd1000); rd(9, v); chk("R10 counter load", v, 32'd1000);
    repeat (10) tick();
    rd(9, v); chk("R10 counter step", v, 32'd1010);

    // timer match
    rd(9, c);
    wr(11, c + 32'd6);
    for (int k = 1; k <= 10; k++) begin
      tick(); rd(13, v);
      chk("R11 timer pending", {31'd0, v[15]}, (k >= 6) ? 32'd1 : 32'd0);
    end
    wr(11, c + 32'd100000); rd(13, v); chk("R11 match write clears", {31'd0, v[15]}, 32'd0);

    // software pending
    wr(13, 32'hFFFF_FFFF); rd(13, v); chk("R13 only sw bits", v, 32'h0000_0300);
    wr(13, 32'h0000_0100);
    next_pc = 32'h0000_5550;
    reg_wr = 1; reg_sel = 12; reg_wdata = 32'h0000_0101; tick(); reg_wr = 0;
    #0.2; chk("R7 sw level taken", {31'd0, redirect}, 32'd1);
    chk("R7 vector", redirect_pc, VEC);
    tick();
    rd(12, v); chk("R7 exl set", {31'd0, v[1]}, 32'd1);
    rd(14, v); chk("R7 resume next", v, 32'h0000_5550);
    wr(13, 0);
    do_ret(32'h0000_5550);
    rd(12, v); chk("R9 exl clear", {31'd0, v[1]}, 32'd0);
    wr(12, 0);

    // hardware line sweep
    for (int i = 0; i < 6; i++) begin
      for (int m = 0; m < 256; m++) begin
        logic taken;
        taken = m[2+i];
        wr(12, {16'd0, m[7:0], 8'h01});
        next_pc = 32'h0001_0000 + ((i * 256 + m) * 4);
        hw_irq = 6'd1 << i;
        tick();
        rd(13, v); chk("R6 pending regardless of mask", {31'd0, v[10+i]}, 32'd1);
        chk("R7 take decision", {31'd0, redirect}, {31'd0, taken});
        hw_irq = 0;
        tick();
        rd(12, v); chk("R7 exl after", {31'd0, v[1]}, {31'd0, taken});
        if (taken) begin
          rd(14, v); chk("R7 resume", v, next_pc);
          rd(13, v); chk("R7 code 0, line dropped", v, 32'd0);
          do_ret(next_pc);
        end
      end
    end
    // enable off, and exception level set
    wr(12, 32'h0000_FF00); hw_irq = 6'h3F; tick(); tick();
    chk("R7 enable off blocks", {31'd0, redirect}, 32'd0);
    hw_irq = 0; wr(12, 32'h0000_FF03); hw_irq = 6'h3F; tick(); tick();
    chk("R7 exl blocks", {31'd0, redirect}, 32'd0);
    hw_irq = 0; tick(); wr(12, 0);

    // exceptions
    exp_fault = 32'd0;
    for (int j = 0; j < 12; j++) begin
      for (int s = 0; s < 2; s++) begin
        exc_req = 1; exc_code = codes[j]; exc_in_slot = s[0];
        exc_pc = 32'h0000_4000 + j * 64 + s * 8;
        exc_bad_addr = 32'hBAD0_0000 | (j * 2 + s);
        #0.2;
        chk("R3 redirect", {31'd0, redirect}, 32'd1);
        chk("R3 vector", redirect_pc, VEC);
        exp_resume = s ? exc_pc - 32'd4 : exc_pc;
        if (codes[j] == 4 || codes[j] == 5) exp_fault = exc_bad_addr;
        tick(); exc_req = 0;
        rd(12, v); chk("R3 exl", {31'd0, v[1]}, 32'd1);
        rd(13, v); chk("R3 code", {27'd0, v[6:2]}, {27'd0, codes[j]});
        chk("R4 slot flag", {31'd0, v[31]}, s);
        rd(14, v); chk("R4 resume", v, exp_resume);
        rd(8, v);  chk("R12 fault addr", v, exp_fault);
        // nested
        exc_req = 1; exc_code = 5'd12; exc_in_slot = ~s[0]; exc_pc = 32'hDEAD_0000;
        #0.2; chk("R5 nested redirect", redirect_pc, VEC);
        tick(); exc_req = 0;
        rd(14, v); chk("R5 resume frozen", v, exp_resume);
        rd(13, v); chk("R5 code updated", {27'd0, v[6:2]}, 32'd12);
        chk("R5 slot frozen", {31'd0, v[31]}, s);
        rd(8, v);  chk("R12 fault kept", v, exp_fault);
        do_ret(exp_resume);
      end
    end

    // precedence
    wr(12, 32'h0000_FF01);
    hw_irq = 6'd1; tick();
    exc_req = 1; exc_code = 5'd10; exc_pc = 32'h0000_2000; exc_in_slot = 0;
    next_pc = 32'h0000_3000;
    reg_wr = 1; reg_sel = 12; reg_wdata = 32'd0;
    tick(); exc_req = 0; reg_wr = 0; hw_irq = 0;
    rd(13, v); chk("R8 exception code wins", {27'd0, v[6:2]}, 32'd10);
    rd(14, v); chk("R8 exception resume", v, 32'h0000_2000);
    rd(12, v); chk("R8 write discarded", v, 32'h0000_FF03);
    do_ret(32'h0000_2000);
    wr(12, 0);

    done = 1;
    summary();
  end
endmodule